// File: doc/BRIEF.md
# Codec setup sequencer

This block takes over the setup of a serial audio codec from the processor. Once reset is released it sends a fixed list of 16-bit control words to the codec over a synchronous serial transmit line. The codec is the timing master and supplies both the bit clock and an active-low frame sync. Each codec register write takes two frames. The first frame carries a request word (0x0001) that tells the codec the next frame holds control data. The second frame carries the register address and the 8-bit value to write.

Both serial inputs are sampled into the system clock domain through two-flop synchronizers. The transmit data changes only on a detected rising edge of the bit clock. A one-word transmit holder tells the sequencer when the previous word has been fully shifted out, and the sequencer loads the next word only then. After the last word it raises a done flag. That flag stays high until reset or until a start pulse replays the whole list.

Top module: `codec_cfg_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `ser_dout` is 0 and `cfg_done` is 0.
- R2: A word is sent most significant bit first. Bit 15 is driven on the rising `ser_clk` edge at which `ser_fs_n` is sampled low. Each following rising edge drives the next lower bit, so 16 edges carry the word. `ser_dout` changes only after a rising `ser_clk` edge.
- R3: Each register write is two consecutive frames. The first is the request word 0x0001. The second is the control word: bits 15 to 11 are zero, bits 10 to 8 hold the address and bits 7 to 0 hold the value.
- R4: The writes go out in this order as (address, value): (1, 0x80) codec reset; (1, 0x00) leave reset and select the differential input; (2, 0x00) telephone mode off; (4, rate value); (3, 0x00) no slave devices. That is ten frames in total.
- R5: The rate value written to register 4 has bits 6 to 4 equal to the parameter `RATE_N` and all other bits zero. The default `RATE_N` of 6 gives 0x60, which is 8.192 MHz / (128 × 6), or about 10666 Hz.
- R6: No word ever sent has address 5 or 6 in bits 10 to 8.
- R7: A new word is loaded only after the previous one has been fully shifted out. A frame that occurs while no word is loaded, and every bit period between frames, shows `ser_dout` = 0.
- R8: `cfg_done` goes to 1 after the tenth word has been fully sent. It then stays at 1 across any later frames until reset or a start pulse.
- R9: A `cfg_start` pulse while `cfg_done` is 1 clears `cfg_done` on the next clock and replays the list from the first word. A pulse while the list is still running is ignored.
- R10: Asserting reset in the middle of the list returns the block to its R1 state. After release, the block replays the list from the first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_start | input | 1 | Replays the setup list when pulsed after completion |
| ser_clk | input | 1 | Bit clock from the codec |
| ser_fs_n | input | 1 | Active-low frame sync from the codec |
| ser_dout | output | 1 | Serial control data to the codec |
| cfg_done | output | 1 | High once the whole list has been sent |

## Verification
The bench acts as the codec. It sweeps two bit-clock speeds and rebuilds every received word from the serial line.

- It compares each word with the request/control pairs computed from the address and value list. A design that dropped the request word, swapped the order or shifted out LSB first would show a mismatch in the very first frames.
- Idle frames and the gaps between frames must read zero. A design that reloaded early or sent a stale word would put bits there.
- It checks the rate field arithmetically against the expected conversion rate.
- It pulses start both mid-run and after completion. A design that restarted while busy would repeat the first pair out of order.
- It resets the block in the middle of the list. A design that failed to clear the step counter would resume from the middle instead of the first word.

// File: rtl/codec_cfg_pkg.sv
`timescale 1ns/1ps
package codec_cfg_pkg;

  localparam int WORD_W   = 16;
  localparam int N_WRITES = 5;
  localparam int N_WORDS  = 2 * N_WRITES;
  localparam int STEP_W   = $clog2(N_WORDS);
  localparam int BIT_W    = $clog2(WORD_W);
  localparam logic [WORD_W-1:0] REQ_WORD = 16'h0001;

  typedef enum logic [1:0] {SQ_LOAD, SQ_WAIT, SQ_DONE} seq_state_t;
  typedef enum logic [1:0] {SH_IDLE, SH_ARMED, SH_SHIFT} sh_state_t;

  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] val;
  } reg_write_t;

  function automatic reg_write_t write_entry(input logic [STEP_W-1:0] k,
                                             input logic [2:0] rate_n);
    reg_write_t e;
    case (k)
      'd0:     e = '{addr: 3'd1, val: 8'h80};
      'd1:     e = '{addr: 3'd1, val: 8'h00};
      'd2:     e = '{addr: 3'd2, val: 8'h00};
      'd3:     e = '{addr: 3'd4, val: {1'b0, rate_n, 4'h0}};
      default: e = '{addr: 3'd3, val: 8'h00};
    endcase
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_word(input reg_write_t e);
    return {5'b00000, e.addr, e.val};
  endfunction

endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/cfg_rom.sv
`timescale 1ns/1ps
module cfg_rom
  import codec_cfg_pkg::*;
#(
  parameter logic [2:0] RATE_N = 3'd6
) (
  input  logic [STEP_W-1:0] step,
  output logic [WORD_W-1:0] word
);

  logic [STEP_W-1:0] pair_idx;
  reg_write_t        entry;

  assign pair_idx = step >> 1;
  assign entry    = write_entry(pair_idx, RATE_N);
  assign word     = step[0] ? ctrl_word(entry) : REQ_WORD;

endmodule

// File: rtl/cfg_tx_shifter.sv
`timescale 1ns/1ps
module cfg_tx_shifter
  import codec_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_s,
  input  logic              fsn_s,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              ready,
  output logic              sdata
);

  sh_state_t         state_q, state_d;
  logic [WORD_W-1:0] hold_q;
  logic [BIT_W-1:0]  idx_q, idx_d;
  logic              sd_q, sd_d;
  logic              bclk_d_q;
  logic              bclk_rise;
  logic              hold_en;

  assign bclk_rise = bclk_s & ~bclk_d_q;
  assign ready     = (state_q == SH_IDLE);
  assign hold_en   = load & ready;
  assign sdata     = sd_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sd_d    = sd_q;
    case (state_q)
      SH_IDLE: begin
        if (load) state_d = SH_ARMED;
      end
      SH_ARMED: begin
        if (bclk_rise && !fsn_s) begin
          state_d = SH_SHIFT;
          idx_d   = BIT_W'(WORD_W - 1);
          sd_d    = hold_q[WORD_W-1];
        end
      end
      SH_SHIFT: begin
        if (bclk_rise) begin
          if (idx_q == '0) begin
            state_d = SH_IDLE;
            sd_d    = 1'b0;
          end else begin
            idx_d = idx_q - 1'b1;
            sd_d  = hold_q[idx_q - 1'b1];
          end
        end
      end
      default: state_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SH_IDLE;
      idx_q    <= '0;
      sd_q     <= 1'b0;
      bclk_d_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      sd_q     <= sd_d;
      bclk_d_q <= bclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= word;
  end

  // R7
  load_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ready);

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(load));

  // R6
  no_reserved_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (word[10:8] != 3'd5 && word[10:8] != 3'd6));

  // R2
  dout_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_rise |=> $stable(sdata));

endmodule

// File: rtl/cfg_sequencer.sv
`timescale 1ns/1ps
module cfg_sequencer
  import codec_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tx_ready,
  output logic [STEP_W-1:0] step,
  output logic              load,
  output logic              done
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_WORDS - 1);

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    load    = 1'b0;
    case (state_q)
      SQ_LOAD: begin
        if (tx_ready) begin
          load    = 1'b1;
          state_d = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (tx_ready) begin
          if (step_q == LAST_STEP) begin
            state_d = SQ_DONE;
          end else begin
            step_d  = step_q + 1'b1;
            state_d = SQ_LOAD;
          end
        end
      end
      SQ_DONE: begin
        if (start) begin
          step_d  = '0;
          state_d = SQ_LOAD;
        end
      end
      default: state_d = SQ_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_LOAD;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign step = step_q;
  assign done = (state_q == SQ_DONE);

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8
  done_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> tx_ready);

endmodule

// File: rtl/codec_cfg_seq.sv
`timescale 1ns/1ps
module codec_cfg_seq
  import codec_cfg_pkg::*;
#(
  parameter logic [2:0] RATE_N = 3'd6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_start,
  input  logic ser_clk,
  input  logic ser_fs_n,
  output logic ser_dout,
  output logic cfg_done
);

  logic [1:0]        rst_pipe;
  logic              rst_ns;
  logic [1:0]        ser_sync;
  logic [STEP_W-1:0] step;
  logic [WORD_W-1:0] rom_word;
  logic              tx_load;
  logic              tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  cfg_sync #(
    .W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_ns),
    .din  ({ser_fs_n, ser_clk}),
    .dout (ser_sync)
  );

  cfg_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .start   (cfg_start),
    .tx_ready(tx_ready),
    .step    (step),
    .load    (tx_load),
    .done    (cfg_done)
  );

  cfg_rom #(.RATE_N(RATE_N)) u_rom (
    .step(step),
    .word(rom_word)
  );

  cfg_tx_shifter u_tx (
    .clk   (clk),
    .rst_n (rst_ns),
    .bclk_s(ser_sync[0]),
    .fsn_s (ser_sync[1]),
    .load  (tx_load),
    .word  (rom_word),
    .ready (tx_ready),
    .sdata (ser_dout)
  );

endmodule

// File: tb/codec_cfg_seq_test.sv
`timescale 1ns/1ps
module codec_cfg_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_start = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_fs_n = 1'b1;
  logic ser_dout;
  logic cfg_done;

  int tests = 0;
  int fails = 0;
  int half = 8;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  codec_cfg_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
    .ser_clk(ser_clk), .ser_fs_n(ser_fs_n),
    .ser_dout(ser_dout), .cfg_done(cfg_done)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int k);
    logic [2:0] a;
    logic [7:0] v;
    if (k % 2 == 0) return 16'h0001;
    case (k / 2)
      0: begin a = 3'd1; v = 8'h80; end
      1: begin a = 3'd1; v = 8'h00; end
      2: begin a = 3'd2; v = 8'h00; end
      3: begin a = 3'd4; v = 8'(6 << 4); end
      default: begin a = 3'd3; v = 8'h00; end
    endcase
    return {5'd0, a, v};
  endfunction

  task automatic bhalf();
    repeat (half) @(negedge clk);
  endtask

  // one codec frame: fs low across the first rising edge, 16 bits, 4 idle periods
  task automatic frame(output logic [15:0] w, input int start_at_bit);
    w = '0;
    ser_fs_n = 1'b0;
    for (int b = 15; b >= 0; b--) begin
      bhalf();
      ser_clk = 1'b1;
      if (b == start_at_bit) cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
      repeat (half - 1) @(negedge clk);
      w[b] = ser_dout;
      ser_clk = 1'b0;
      ser_fs_n = 1'b1;
    end
    for (int g = 0; g < 4; g++) begin
      bhalf();
      ser_clk = 1'b1;
      bhalf();
      chk(ser_dout == 1'b0, "R7 gap line low", {15'd0, ser_dout}, 16'h0000);
      ser_clk = 1'b0;
    end
  endtask

  task automatic run_list(input int first, input int start_frame);
    logic [15:0] w;
    for (int k = first; k < 10; k++) begin
      if (k == 9) chk(cfg_done == 1'b0, "R8 done low before last", {15'd0, cfg_done}, 16'h0000);
      frame(w, (k == start_frame) ? 8 : -1);
      chk(w == exp_word(k), (k % 2 == 0) ? "R3 request word" : "R4 control word order", w, exp_word(k));
      chk(!(w[15:11] == 5'd0 && (w[10:8] == 3'd5 || w[10:8] == 3'd6)), "R6 reserved addr", w, exp_word(k));
      if (k == 7) begin
        int n = int'(w[6:4]);
        int rate = (n == 0) ? 0 : 8192000 / (128 * n);
        chk(rate == 10666, "R5 conversion rate", 16'(rate), 16'(10666));
      end
    end
    chk(cfg_done == 1'b1, "R8 done after tenth word", {15'd0, cfg_done}, 16'h0001);
    for (int i = 0; i < 2; i++) begin
      frame(w, -1);
      chk(w == 16'h0000, "R7 idle frame zero", w, 16'h0000);
      chk(cfg_done == 1'b1, "R8 done sticky", {15'd0, cfg_done}, 16'h0001);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    chk(ser_dout == 1'b0 && cfg_done == 1'b0, "R1 in reset", {14'd0, ser_dout, cfg_done}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_dout == 1'b0 && cfg_done == 1'b0, "R1 after release", {14'd0, ser_dout, cfg_done}, 16'h0000);
    repeat (4) @(negedge clk);

    // slow bit clock, start pulse mid-run must be ignored (R9)
    half = 8;
    run_list(0, 2);

    // restart after completion (R9), faster bit clock (R2 sweep)
    half = 5;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(cfg_done == 1'b0, "R9 done cleared by start", {15'd0, cfg_done}, 16'h0000);
    run_list(0, -1);

    // reset in the middle of the list (R10)
    half = 6;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      frame(w, -1);
      chk(w == exp_word(k), "R10 words before reset", w, exp_word(k));
    end
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(ser_dout == 1'b0 && cfg_done == 1'b0, "R10 state in reset", {14'd0, ser_dout, cfg_done}, 16'h0000);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    run_list(0, -1);

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %h expected %h", 16'h0000, 16'h0001);
    summary();
  end

endmodule